// File: doc/BRIEF.md
# Sequential Filter Coefficient Loader

This block is the write side of a shared tap memory that serves three cascaded low-pass FIR stages. Software sets a starting location once through a pointer register. It then streams coefficients through a data register. Every accepted data write becomes a single-cycle write on the memory port and advances the pointer by one. Coefficients are therefore packed back to back: first all taps of the first stage, then the second stage, then the third.

Each stage has a control register with these fields:

- tap count
- decimation factor
- rounding mode
- enable

The block publishes these values per stage. It also derives each stage's base location in the shared memory from the tap counts of the stages ahead of it. The stages can then find their taps without any extra software setup.

A control write that would bring the combined tap count to the memory depth or beyond is refused whole. A data write aimed past the end of the memory does nothing except raise a sticky overflow flag. The FIR arithmetic is not part of this block.

Top module: `coef_loader`

## Requirements
- R1: After reset the tap counts of stages 0, 1 and 2 are 87, 33 and 119. Every decimation factor is 2. The rounding modes are 1, 0 and 1. All enables are 0. The bases are 0, 87 and 120. `overflow` and `memWe` are 0.
- R2: A bus write to offset 0x24 loads the pointer with `wrData[8:0]` and clears `overflow`.
- R3: A bus write to offset 0x28 with the pointer below 336 raises `memWe` for exactly the next cycle, with `memAddr` equal to the pointer and `memData` equal to `wrData[23:0]`. The pointer then advances by one.
- R4: Back-to-back data writes land on consecutive memory locations.
- R5: A data write while the pointer is 336 or more produces no memory write, leaves the pointer unchanged and sets `overflow`.
- R6: A bus write to offset 0x0C, 0x10 or 0x14 configures stage 0, 1 or 2 respectively, one cycle later. The fields are: tap count in bits [8:0], decimation factor in [15:12], rounding mode in [17:16] and enable in bit 31.
- R7: A control write is ignored entirely when the new tap count plus the other two stages' tap counts would reach 336 or more.
- R8: The base of stage k equals the sum of the tap counts of stages 0 to k-1, and it follows every accepted control write.
- R9: Writes to any other offset, and cycles with `wrEn` low, change neither the configuration nor the pointer, and produce no memory write.
- R10: Once set, `overflow` stays set through later data writes and idle cycles until the next pointer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register byte offset |
| wrData | input | 32 | Register write data |
| memWe | output | 1 | Tap memory write enable |
| memAddr | output | 9 | Tap memory write location |
| memData | output | 24 | Tap coefficient, two's complement |
| overflow | output | 1 | Sticky flag: data write past the memory end |
| filtEn | output | 3 | Per-stage enable |
| filtLen | output | 27 | Per-stage tap count, 9 bits each, stage 0 in the low bits |
| filtBase | output | 27 | Per-stage base location, 9 bits each |
| filtDecim | output | 12 | Per-stage decimation factor, 4 bits each |
| filtRound | output | 6 | Per-stage rounding mode, 2 bits each |

## Verification
The data path is driven in three ways:

- A short burst from location 0. This checks the increment and the truncation of the upper data bits, using a negative coefficient with junk above bit 23.
- A burst that starts two locations below the end. This separates the last legal write from the first refused one.
- Writes to stray offsets and with the strobe low, followed by one more data write. That write's location proves the pointer was left alone.

The configuration path is tried with a legal update to the middle stage, which moves only the last base. It is then tried at the acceptance limit with totals of 369, exactly 336 and 335. These show where the limit lies and that a refused write alters no field.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             addrWr;
    logic             dataWr;
    logic             ctlWr;
    logic [IDX_W-1:0] ctlIdx;
  } strobe_t;
endpackage

// File: rtl/coef_loader_ctrl.sv
module coef_loader_ctrl
  import coef_loader_pkg::*;
#(
  parameter int BUS_AW   = 8,
  parameter int NUM_FILT = 3,
  parameter int PTR_OFS  = 'h24,
  parameter int DATA_OFS = 'h28,
  parameter int CTL_OFS  = 'h0C
) (
  input  logic              wrEn,
  input  logic [BUS_AW-1:0] wrAddr,
  output strobe_t           strb
);
  always_comb begin
    strb        = '0;
    strb.addrWr = wrEn && (wrAddr == BUS_AW'(PTR_OFS));
    strb.dataWr = wrEn && (wrAddr == BUS_AW'(DATA_OFS));
    for (int k = 0; k < NUM_FILT; k++) begin
      if (wrEn && (wrAddr == BUS_AW'(CTL_OFS + 4 * k))) begin
        strb.ctlWr  = 1'b1;
        strb.ctlIdx = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/coef_loader_dp.sv
module coef_loader_dp
  import coef_loader_pkg::*;
#(
  parameter int NUM_FILT = 3,
  parameter int TAP_W    = 9,
  parameter int COEF_W   = 24,
  parameter int DEC_W    = 4,
  parameter int RND_W    = 2,
  parameter int MAX_TAPS = 336,
  parameter logic [NUM_FILT*TAP_W-1:0] DEF_LEN = {9'd119, 9'd33, 9'd87},
  parameter logic [NUM_FILT*DEC_W-1:0] DEF_DEC = {4'd2, 4'd2, 4'd2},
  parameter logic [NUM_FILT*RND_W-1:0] DEF_RND = {2'd1, 2'd0, 2'd1}
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strb,
  input  logic [31:0]               wrData,
  output logic                      memWe,
  output logic [TAP_W-1:0]          memAddr,
  output logic [COEF_W-1:0]         memData,
  output logic                      overflow,
  output logic [NUM_FILT-1:0]       filtEn,
  output logic [NUM_FILT*TAP_W-1:0] filtLen,
  output logic [NUM_FILT*TAP_W-1:0] filtBase,
  output logic [NUM_FILT*DEC_W-1:0] filtDecim,
  output logic [NUM_FILT*RND_W-1:0] filtRound
);
  localparam int SUM_W   = TAP_W + $clog2(NUM_FILT) + 1;
  localparam int DEC_LSB = 12;
  localparam int RND_LSB = 16;
  localparam int EN_BIT  = 31;

  logic [TAP_W-1:0] ptrQ;
  logic [TAP_W-1:0] lenQ  [NUM_FILT];
  logic [DEC_W-1:0] decQ  [NUM_FILT];
  logic [RND_W-1:0] rndQ  [NUM_FILT];
  logic [TAP_W-1:0] baseC [NUM_FILT];
  logic [SUM_W-1:0] otherSum;
  logic [SUM_W-1:0] candTotal;
  logic             cfgOk;
  logic             ptrInRange;

  assign ptrInRange = (SUM_W'(ptrQ) < SUM_W'(MAX_TAPS));

  // Limit check for the stage being written: the other stages plus the new count.
  always_comb begin
    otherSum = '0;
    for (int k = 0; k < NUM_FILT; k++) begin
      if (strb.ctlIdx != IDX_W'(k)) otherSum = otherSum + SUM_W'(lenQ[k]);
    end
    candTotal = otherSum + SUM_W'(wrData[TAP_W-1:0]);
    cfgOk     = candTotal < SUM_W'(MAX_TAPS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ     <= '0;
      memWe    <= 1'b0;
      memAddr  <= '0;
      memData  <= '0;
      overflow <= 1'b0;
    end else begin
      memWe <= 1'b0;
      if (strb.addrWr) begin
        ptrQ     <= wrData[TAP_W-1:0];
        overflow <= 1'b0;
      end else if (strb.dataWr) begin
        if (ptrInRange) begin
          memWe   <= 1'b1;
          memAddr <= ptrQ;
          memData <= wrData[COEF_W-1:0];
          ptrQ    <= ptrQ + 1'b1;
        end else begin
          overflow <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_FILT; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lenQ[g]   <= DEF_LEN[g*TAP_W +: TAP_W];
        decQ[g]   <= DEF_DEC[g*DEC_W +: DEC_W];
        rndQ[g]   <= DEF_RND[g*RND_W +: RND_W];
        filtEn[g] <= 1'b0;
      end else if (strb.ctlWr && strb.ctlIdx == IDX_W'(g) && cfgOk) begin
        lenQ[g]   <= wrData[TAP_W-1:0];
        decQ[g]   <= wrData[DEC_LSB +: DEC_W];
        rndQ[g]   <= wrData[RND_LSB +: RND_W];
        filtEn[g] <= wrData[EN_BIT];
      end
    end

    if (g == 0) begin : gFirst
      assign baseC[g] = '0;
    end else begin : gNext
      assign baseC[g] = baseC[g-1] + lenQ[g-1];
    end

    assign filtLen[g*TAP_W +: TAP_W]   = lenQ[g];
    assign filtBase[g*TAP_W +: TAP_W]  = baseC[g];
    assign filtDecim[g*DEC_W +: DEC_W] = decQ[g];
    assign filtRound[g*RND_W +: RND_W] = rndQ[g];
  end
endmodule

// File: rtl/coef_loader.sv
module coef_loader
  import coef_loader_pkg::*;
#(
  parameter int BUS_AW   = 8,
  parameter int NUM_FILT = 3,
  parameter int TAP_W    = 9,
  parameter int COEF_W   = 24,
  parameter int DEC_W    = 4,
  parameter int RND_W    = 2,
  parameter int MAX_TAPS = 336
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [BUS_AW-1:0]         wrAddr,
  input  logic [31:0]               wrData,
  output logic                      memWe,
  output logic [TAP_W-1:0]          memAddr,
  output logic [COEF_W-1:0]         memData,
  output logic                      overflow,
  output logic [NUM_FILT-1:0]       filtEn,
  output logic [NUM_FILT*TAP_W-1:0] filtLen,
  output logic [NUM_FILT*TAP_W-1:0] filtBase,
  output logic [NUM_FILT*DEC_W-1:0] filtDecim,
  output logic [NUM_FILT*RND_W-1:0] filtRound
);
  strobe_t strb;

  coef_loader_ctrl #(
    .BUS_AW(BUS_AW), .NUM_FILT(NUM_FILT)
  ) ctrl_i (
    .wrEn(wrEn), .wrAddr(wrAddr), .strb(strb)
  );

  coef_loader_dp #(
    .NUM_FILT(NUM_FILT), .TAP_W(TAP_W), .COEF_W(COEF_W),
    .DEC_W(DEC_W), .RND_W(RND_W), .MAX_TAPS(MAX_TAPS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .overflow(overflow), .filtEn(filtEn), .filtLen(filtLen),
    .filtBase(filtBase), .filtDecim(filtDecim), .filtRound(filtRound)
  );
endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
  parameter int BUS_AW   = 8,
  parameter int NUM_FILT = 3,
  parameter int TAP_W    = 9,
  parameter int COEF_W   = 24,
  parameter int MAX_TAPS = 336
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      wrEn,
  input logic [BUS_AW-1:0]         wrAddr,
  input logic [31:0]               wrData,
  input logic                      memWe,
  input logic [TAP_W-1:0]          memAddr,
  input logic [COEF_W-1:0]         memData,
  input logic                      overflow,
  input logic [NUM_FILT*TAP_W-1:0] filtLen
);
  localparam int SUM_W = TAP_W + $clog2(NUM_FILT) + 1;

  logic [SUM_W-1:0] lenSum;
  logic             ptrWr;
  logic             dataWr;
  logic             ctlWr;

  always_comb begin
    lenSum = '0;
    for (int k = 0; k < NUM_FILT; k++) lenSum = lenSum + SUM_W'(filtLen[k*TAP_W +: TAP_W]);
    ctlWr = 1'b0;
    for (int k = 0; k < NUM_FILT; k++) begin
      if (wrEn && wrAddr == BUS_AW'('h0C + 4 * k)) ctlWr = 1'b1;
    end
  end
  assign ptrWr  = wrEn && wrAddr == BUS_AW'('h24);
  assign dataWr = wrEn && wrAddr == BUS_AW'('h28);

  AST_WE_FROM_DATA: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(dataWr)); // R3
  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memData == $past(wrData[COEF_W-1:0])); // R3
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> SUM_W'(memAddr) < SUM_W'(MAX_TAPS)); // R5
  AST_NO_WE_ON_OVF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> !memWe); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !ptrWr |=> overflow); // R10
  AST_TOTAL_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    lenSum < SUM_W'(MAX_TAPS)); // R7
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWr |=> $stable(filtLen)); // R9
endmodule

bind coef_loader coef_loader_chk #(
  .BUS_AW(BUS_AW), .NUM_FILT(NUM_FILT), .TAP_W(TAP_W),
  .COEF_W(COEF_W), .MAX_TAPS(MAX_TAPS)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .memWe(memWe), .memAddr(memAddr), .memData(memData),
  .overflow(overflow), .filtLen(filtLen)
);

// File: tb/coef_loader_tb.sv
module coef_loader_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        memWe, overflow;
  logic [8:0]  memAddr;
  logic [23:0] memData;
  logic [2:0]  filtEn;
  logic [26:0] filtLen, filtBase;
  logic [11:0] filtDecim;
  logic [5:0]  filtRound;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic        obsWe;
  logic [8:0]  obsAddr;
  logic [23:0] obsData;

  always #10 clk = ~clk;

  coef_loader dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .overflow(overflow),
    .filtEn(filtEn), .filtLen(filtLen), .filtBase(filtBase),
    .filtDecim(filtDecim), .filtRound(filtRound)
  );

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    obsWe = memWe; obsAddr = memAddr; obsData = memData;
    wrEn = 1'b0;
  endtask

  function automatic logic [31:0] ctlWord(input logic en, input logic [1:0] rnd,
                                          input logic [3:0] dec, input logic [8:0] taps);
    return {en, 13'd0, rnd, dec, 3'd0, taps};
  endfunction

  task automatic t_reset();
    expect_eq("R1 len", filtLen, {9'd119, 9'd33, 9'd87});
    expect_eq("R1 base", filtBase, {9'd120, 9'd87, 9'd0});
    expect_eq("R1 decim", filtDecim, {4'd2, 4'd2, 4'd2});
    expect_eq("R1 round", filtRound, {2'd1, 2'd0, 2'd1});
    expect_eq("R1 en", filtEn, 3'b000);
    expect_eq("R1 ovf/we", {overflow, memWe}, 2'b00);
  endtask

  task automatic t_burst();
    logic [23:0] vals [5] = '{24'h000014, 24'hffffb2, 24'h7fffff, 24'h800000, 24'h000000};
    busWr(8'h24, 32'h0);
    expect_eq("R2 ptr write no mem", obsWe, 1'b0);
    for (int i = 0; i < 5; i++) begin
      busWr(8'h28, {8'hA5, vals[i]});
      expect_eq("R3 we", obsWe, 1'b1);
      expect_eq("R4 addr", obsAddr, 9'(i));
      expect_eq("R3 data", obsData, vals[i]);
      @(negedge clk);
      expect_eq("R3 we one cycle", memWe, 1'b0);
    end
  endtask

  task automatic t_overflow();
    busWr(8'h24, 32'd334);
    busWr(8'h28, 32'h111);
    expect_eq("R5 last legal-1", {obsWe, obsAddr}, {1'b1, 9'd334});
    busWr(8'h28, 32'h222);
    expect_eq("R5 last legal", {obsWe, obsAddr}, {1'b1, 9'd335});
    expect_eq("R5 no ovf yet", overflow, 1'b0);
    busWr(8'h28, 32'h333);
    expect_eq("R5 refused", obsWe, 1'b0);
    expect_eq("R5 ovf set", overflow, 1'b1);
    busWr(8'h28, 32'h444);
    expect_eq("R10 still refused", obsWe, 1'b0);
    repeat (3) @(negedge clk);
    expect_eq("R10 sticky", overflow, 1'b1);
    busWr(8'h24, 32'd7);
    expect_eq("R2 ovf cleared", overflow, 1'b0);
    busWr(8'h28, 32'h555);
    expect_eq("R2 ptr loaded", {obsWe, obsAddr}, {1'b1, 9'd7});
  endtask

  task automatic t_config();
    busWr(8'h10, ctlWord(1'b1, 2'd2, 4'd3, 9'd50));
    expect_eq("R6 len", filtLen, {9'd119, 9'd50, 9'd87});
    expect_eq("R6 decim", filtDecim, {4'd2, 4'd3, 4'd2});
    expect_eq("R6 round", filtRound, {2'd1, 2'd2, 2'd1});
    expect_eq("R6 en", filtEn, 3'b010);
    expect_eq("R8 base", filtBase, {9'd137, 9'd87, 9'd0});
    busWr(8'h0C, ctlWord(1'b1, 2'd3, 4'd9, 9'd200));
    expect_eq("R7 reject len", filtLen, {9'd119, 9'd50, 9'd87});
    expect_eq("R7 reject fields", {filtEn, filtDecim[3:0], filtRound[1:0]}, {3'b010, 4'd2, 2'd1});
    busWr(8'h0C, ctlWord(1'b1, 2'd3, 4'd9, 9'd167));
    expect_eq("R7 reject at 336", filtLen, {9'd119, 9'd50, 9'd87});
    busWr(8'h0C, ctlWord(1'b1, 2'd3, 4'd9, 9'd166));
    expect_eq("R7 accept at 335", filtLen, {9'd119, 9'd50, 9'd166});
    expect_eq("R6 stage0 fields", {filtEn, filtDecim[3:0], filtRound[1:0]}, {3'b011, 4'd9, 2'd3});
    expect_eq("R8 base moved", filtBase, {9'd216, 9'd166, 9'd0});
    busWr(8'h14, ctlWord(1'b1, 2'd0, 4'd1, 9'd10));
    expect_eq("R8 last stage", {filtLen[26:18], filtBase}, {9'd10, 9'd216, 9'd166, 9'd0});
  endtask

  task automatic t_ignore();
    logic [26:0] lenBefore;
    lenBefore = filtLen;
    busWr(8'h24, 32'd20);
    busWr(8'h18, ctlWord(1'b1, 2'd1, 4'd1, 9'd1));
    expect_eq("R9 stray ctl", filtLen, lenBefore);
    busWr(8'h2C, 32'h123);
    expect_eq("R9 stray data", obsWe, 1'b0);
    @(negedge clk);
    wrEn = 1'b0; wrAddr = 8'h28; wrData = 32'h999;
    @(negedge clk);
    expect_eq("R9 strobe low", memWe, 1'b0);
    wrAddr = 8'h0C; wrData = ctlWord(1'b0, 2'd0, 4'd0, 9'd1);
    @(negedge clk);
    expect_eq("R9 strobe low ctl", filtLen, lenBefore);
    busWr(8'h28, 32'h0abcde);
    expect_eq("R9 ptr untouched", {obsWe, obsAddr, obsData}, {1'b1, 9'd20, 24'h0abcde});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_burst();
    t_overflow();
    t_config();
    t_ignore();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule